// File: doc/BRIEF.md
# Filtered External Interrupt Edge Detector

This block sits between five asynchronous interrupt pins and the interrupt latch of a controller. Each pin is first brought into the clock domain by a two-flop synchronizer. It then passes through a digital noise filter that samples the pin at a fixed interval for each channel. The filter only takes a new level after three consecutive samples agree on it. Each filtered signal feeds a trigger detector. The detector emits a one-cycle set pulse on the selected transition, or holds the set line high while the signal is high when level mode is selected.

Channel 0 and channel 4 use a short window and trigger only on falling edges. Channel 0 produces requests only while its pin-function bit is set. Channel 1 has a rising/falling select and two filter lengths chosen at run time. Channels 2 and 3 each take a 2-bit trigger mode. A master enable and a per-channel source enable, both driven from outside, gate every set output.

One 8-bit control register holds the configuration. When a write changes a channel's settings, that channel's filter is restarted and its edge reports are blanked for one accept window. The same blanking applies to all channels after reset.

Top module: `xirq_edge_unit`

## Requirements
- R1: After reset the control register reads 0x00, `ch0_pin_sel` is 0 and no set output is active.
- R2: A write stores bits 7..1 of `cfg_wdata`. Bit 0 always reads 0. Field positions: bit7 = channel 1 short-filter select, bit6 = channel 0 pin-function enable, bits5:4 = channel 3 mode, bits3:2 = channel 2 mode, bit1 = channel 1 falling-edge select.
- R3: On channels 0 and 4, a pin pulse shorter than 2 clocks is never reported, and a pulse of 7 clocks or more is always reported.
- R4: On channels 2 and 3, a pulse shorter than 7 clocks is never reported, and a pulse of 25 clocks or more is always reported, in every trigger mode.
- R5: On channel 1, select bit7=0 rejects pulses shorter than 63 clocks and accepts pulses of 193 or more. Select bit7=1 rejects pulses shorter than 15 clocks and accepts pulses of 49 or more.
- R6: The channel 2/3 mode code works as follows: 00 reports rising edges, 01 falling edges, 10 both edges. With 11 the set output is high on every cycle that the filtered input is high.
- R7: Channel 1 reports rising edges when bit1=0 and falling edges when bit1=1. Channels 0 and 4 report falling edges only.
- R8: With bit6=0, channel 0 never raises its set output. `ch0_pin_sel` equals bit6.
- R9: When `master_en` is 0, or a channel's `src_en` bit is 0, that channel's set output stays 0.
- R10: Each qualifying transition in an edge mode yields exactly one set pulse, one cycle wide.
- R11: After a write that changes a channel's settings, that channel's filter restarts, and no edge is reported on it for 3 sample intervals plus 4 cycles. The same blanking applies to every channel after reset.
- R12: Filters reset to each channel's idle level: high for channels 0 and 4, low for the others. A pin held steady through reset yields no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 5 | Raw asynchronous interrupt pins, one per channel |
| master_en | input | 1 | Global interrupt enable |
| src_en | input | 5 | Per-channel source enables |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| ch0_pin_sel | output | 1 | Channel 0 pin-function enable toward the port mux |
| irq_set | output | 5 | Per-channel set requests toward the interrupt latch |

## Verification
The checker watches several rules on every cycle: the zero read-back bit, the gating by the master and source enables and by the channel 0 pin bit, the falling-only nature and one-cycle width of the fixed channels, level mode following the filtered signal, and the silence right after a write that flips channel 0's pin bit. Only the bench scenarios can show the pulse-width thresholds of each filter length in every mode, the direction of each edge select (seen as whether the report lands during the pulse or after it), blanking around a write that restarts a filter, and quiet behaviour across reset with pins held steady.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int unsigned NCH = 5;

    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_BOTH = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_e;

    // Field positions are visible to software and must stay fixed.
    typedef struct packed {
        logic       ch1_short;
        logic       ch0_pin;
        logic [1:0] ch3_trig;
        logic [1:0] ch2_trig;
        logic       ch1_fall;
        logic       spare;
    } ctl_t;

endpackage

// File: rtl/xirq_ctl_reg.sv
module xirq_ctl_reg
    import xirq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [7:0]     wdata,
    output ctl_t           ctl,
    output logic [NCH-1:0] chg,
    output logic [7:0]     rdata
);

    ctl_t ctl_d, ctl_q;
    ctl_t wr;

    always_comb begin
        wr       = ctl_t'(wdata);
        wr.spare = 1'b0;
        ctl_d    = ctl_q;
        chg      = '0;
        if (we) begin
            ctl_d  = wr;
            chg[0] = wr.ch0_pin != ctl_q.ch0_pin;
            chg[1] = (wr.ch1_short != ctl_q.ch1_short) || (wr.ch1_fall != ctl_q.ch1_fall);
            chg[2] = wr.ch2_trig != ctl_q.ch2_trig;
            chg[3] = wr.ch3_trig != ctl_q.ch3_trig;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl   = ctl_q;
    assign rdata = {ctl_q[7:1], 1'b0};

endmodule

// File: rtl/xirq_glitch_filter.sv
module xirq_glitch_filter #(
    parameter int unsigned PER_W = 7,
    parameter logic        IDLE  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PER_W-1:0] per_m1,
    input  logic             raw,
    output logic             filt
);

    localparam logic [1:0] AGREE_LAST = 2'd2;

    typedef struct packed {
        logic [1:0]       sync;
        logic [PER_W-1:0] tick;
        logic [1:0]       agree;
        logic             lvl;
    } flt_t;

    flt_t d, q;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw};
        if (clr) begin
            d.tick  = '0;
            d.agree = '0;
        end else if (q.tick == per_m1) begin
            d.tick = '0;
            if (q.sync[1] == q.lvl) begin
                d.agree = '0;
            end else if (q.agree == AGREE_LAST) begin
                d.lvl   = q.sync[1];
                d.agree = '0;
            end else begin
                d.agree = q.agree + 2'd1;
            end
        end else begin
            d.tick = q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync  <= {IDLE, IDLE};
            q.tick  <= '0;
            q.agree <= '0;
            q.lvl   <= IDLE;
        end else begin
            q <= d;
        end
    end

    assign filt = q.lvl;

endmodule

// File: rtl/xirq_trig_detect.sv
module xirq_trig_detect
    import xirq_pkg::*;
#(
    parameter int unsigned BLK_W     = 8,
    parameter logic        IDLE      = 1'b0,
    parameter int unsigned BLANK_RST = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             filt,
    input  trig_e            trig,
    input  logic             gate,
    input  logic             arm,
    input  logic [BLK_W-1:0] arm_len,
    output logic             set
);

    typedef struct packed {
        logic             prev;
        logic [BLK_W-1:0] blank;
    } det_t;

    det_t d, q;
    logic rise, fall, hit;

    always_comb begin
        d      = q;
        d.prev = filt;
        if (arm)                d.blank = arm_len;
        else if (q.blank != '0) d.blank = q.blank - 1'b1;

        rise = filt & ~q.prev;
        fall = ~filt & q.prev;
        unique case (trig)
            TRIG_RISE: hit = rise;
            TRIG_FALL: hit = fall;
            TRIG_BOTH: hit = rise | fall;
            default:   hit = filt;
        endcase

        if (trig == TRIG_HIGH) set = gate & filt;
        else                   set = gate & hit & (q.blank == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.prev  <= IDLE;
            q.blank <= BLK_W'(BLANK_RST);
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/xirq_edge_unit.sv
module xirq_edge_unit
    import xirq_pkg::*;
#(
    parameter int unsigned FAST_PER  = 2,
    parameter int unsigned MID_PER   = 8,
    parameter int unsigned LONG_PER  = 64,
    parameter int unsigned SHORT_PER = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_in,
    input  logic           master_en,
    input  logic [NCH-1:0] src_en,
    input  logic           cfg_we,
    input  logic [7:0]     cfg_wdata,
    output logic [7:0]     cfg_rdata,
    output logic           ch0_pin_sel,
    output logic [NCH-1:0] irq_set
);

    localparam int unsigned   PER_W     = $clog2(LONG_PER + 1);
    localparam int unsigned   BLK_W     = $clog2(3 * LONG_PER + 5);
    localparam logic [NCH-1:0] IDLE_MASK = 5'b10001;

    function automatic logic [BLK_W-1:0] win_of(input int unsigned per);
        return BLK_W'(3 * per + 4);
    endfunction

    ctl_t             ctl;
    logic [NCH-1:0]   chg;
    logic [NCH-1:0]   filt_w;
    logic [NCH-1:0]   gate;
    logic [PER_W-1:0] per_m1  [NCH];
    trig_e            trig    [NCH];
    logic [BLK_W-1:0] arm_len [NCH];

    xirq_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .ctl   (ctl),
        .chg   (chg),
        .rdata (cfg_rdata)
    );

    always_comb begin
        per_m1[0] = PER_W'(FAST_PER - 1);
        per_m1[1] = ctl.ch1_short ? PER_W'(SHORT_PER - 1) : PER_W'(LONG_PER - 1);
        per_m1[2] = PER_W'(MID_PER - 1);
        per_m1[3] = PER_W'(MID_PER - 1);
        per_m1[4] = PER_W'(FAST_PER - 1);

        trig[0] = TRIG_FALL;
        trig[1] = trig_e'({1'b0, ctl.ch1_fall});
        trig[2] = trig_e'(ctl.ch2_trig);
        trig[3] = trig_e'(ctl.ch3_trig);
        trig[4] = TRIG_FALL;

        arm_len[0] = win_of(FAST_PER);
        arm_len[1] = cfg_wdata[7] ? win_of(SHORT_PER) : win_of(LONG_PER);
        arm_len[2] = win_of(MID_PER);
        arm_len[3] = win_of(MID_PER);
        arm_len[4] = win_of(FAST_PER);

        for (int i = 0; i < NCH; i++) gate[i] = master_en & src_en[i];
        gate[0] = gate[0] & ctl.ch0_pin;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int unsigned RST_PER =
            (g == 0 || g == 4) ? FAST_PER : (g == 1) ? LONG_PER : MID_PER;

        xirq_glitch_filter #(
            .PER_W (PER_W),
            .IDLE  (IDLE_MASK[g])
        ) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (chg[g]),
            .per_m1 (per_m1[g]),
            .raw    (pin_in[g]),
            .filt   (filt_w[g])
        );

        xirq_trig_detect #(
            .BLK_W     (BLK_W),
            .IDLE      (IDLE_MASK[g]),
            .BLANK_RST (3 * RST_PER + 4)
        ) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .filt    (filt_w[g]),
            .trig    (trig[g]),
            .gate    (gate[g]),
            .arm     (chg[g]),
            .arm_len (arm_len[g]),
            .set     (irq_set[g])
        );
    end

    assign ch0_pin_sel = ctl.ch0_pin;

endmodule

// File: rtl/xirq_edge_unit_chk.sv
module xirq_edge_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       master_en,
    input logic [4:0] src_en,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic [4:0] irq_set,
    input logic [4:0] filt
);

    AST_RDATA_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[0] == 1'b0);                                            // R2

    AST_MASTER_GATES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> irq_set == 5'b0);                                  // R9

    AST_SRC_GATES_CH2: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en[2] |-> !irq_set[2]);                                      // R9

    AST_CH0_PIN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[6] |-> !irq_set[0]);                                   // R8

    AST_CH0_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set[0] |-> (!filt[0] && $past(filt[0])));                     // R7

    AST_CH4_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set[4] |=> !irq_set[4]);                                      // R10

    AST_CH2_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[3:2] == 2'b11 && master_en && src_en[2]) |-> irq_set[2] == filt[2]); // R6

    AST_CH0_WRITE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && ($past(cfg_wdata[6]) != $past(cfg_rdata[6]))) |-> !irq_set[0]); // R11

endmodule

bind xirq_edge_unit xirq_edge_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .src_en    (src_en),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .irq_set   (irq_set),
    .filt      (filt_w)
);

// File: tb/xirq_edge_unit_bench.sv
module xirq_edge_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam int SETTLE     = 220;
    localparam logic [4:0] IDLE = 5'b10001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] pin_in = IDLE;
    logic       master_en = 1'b1;
    logic [4:0] src_en = 5'b11111;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       ch0_pin_sel;
    logic [4:0] irq_set;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    xirq_edge_unit u_xirq_edge_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_in      (pin_in),
        .master_en   (master_en),
        .src_en      (src_en),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .ch0_pin_sel (ch0_pin_sel),
        .irq_set     (irq_set)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_ge(input string tag, input int act, input int lo);
        n_checks++;
        if (act < lo) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, lo);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
        repeat (SETTLE) @(negedge clk);
    endtask

    // Drives the active level for width cycles, then idle for tail cycles.
    task automatic pulse_count(input int ch, input int width, input int tail,
                               output int cyc_in, output int cyc_all, output int edges);
        logic last = 1'b0;
        cyc_in = 0; cyc_all = 0; edges = 0;
        for (int k = 0; k < width + tail; k++) begin
            pin_in[ch] = (k < width) ? ~IDLE[ch] : IDLE[ch];
            @(negedge clk);
            if (irq_set[ch]) begin
                cyc_all++;
                if (k < width) cyc_in++;
                if (!last) edges++;
            end
            last = irq_set[ch];
        end
    endtask

    task automatic t_reset;
        int hits = 0;
        pin_in = IDLE | 5'b00100;
        rst_n  = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cfg_rdata after reset", int'(cfg_rdata), 0);
        check("R1 ch0_pin_sel after reset", int'(ch0_pin_sel), 0);
        check("R1 irq_set after reset", int'(irq_set), 0);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (irq_set != 5'b0) hits++;
        end
        check("R12 R11 no report with pins steady through reset", hits, 0);
        pin_in[2] = 1'b0;
        repeat (100) @(negedge clk);
    endtask

    task automatic t_regs;
        write_cfg(8'hFF);
        check("R2 readback of 0xFF", int'(cfg_rdata), 8'hFE);
        check("R8 pin select follows bit6 set", int'(ch0_pin_sel), 1);
        write_cfg(8'hA5);
        check("R2 readback of 0xA5", int'(cfg_rdata), 8'hA4);
        check("R8 pin select follows bit6 clear", int'(ch0_pin_sel), 0);
    endtask

    task automatic t_fast;
        int ci, ca, ed;
        write_cfg(8'h40);
        for (int ch = 0; ch < 5; ch += 4) begin
            pulse_count(ch, 1, 60, ci, ca, ed);
            check($sformatf("R3 ch%0d 1-cycle glitch", ch), ca, 0);
            pulse_count(ch, 7, 60, ci, ca, ed);
            check($sformatf("R3 R10 ch%0d 7-cycle pulse", ch), ca, 1);
            pulse_count(ch, 30, 60, ci, ca, ed);
            check($sformatf("R7 ch%0d falling reported during low pulse", ch), ci, 1);
        end
    endtask

    task automatic t_mid;
        int ci, ca, ed;
        for (int m = 0; m < 4; m++) begin
            write_cfg(8'h40 | 8'(m << 4) | 8'(m << 2));
            for (int ch = 2; ch < 4; ch++) begin
                pulse_count(ch, 6, 80, ci, ca, ed);
                check($sformatf("R4 ch%0d mode%0d 6-cycle glitch", ch, m), ca, 0);
                pulse_count(ch, 25, 80, ci, ca, ed);
                if (m == 3) begin
                    check($sformatf("R6 ch%0d level mode one run", ch), ed, 1);
                    check_ge($sformatf("R4 R6 ch%0d level mode held", ch), ca, 9);
                end else begin
                    check($sformatf("R4 R10 ch%0d mode%0d 25-cycle pulse", ch, m), ca, m == 2 ? 2 : 1);
                end
                pulse_count(ch, 60, 80, ci, ca, ed);
                if (m == 0) check($sformatf("R6 ch%0d rise seen in pulse", ch), ci * 10 + ca, 11);
                if (m == 1) check($sformatf("R6 ch%0d fall seen after pulse", ch), ci * 10 + ca, 1);
                if (m == 2) check($sformatf("R6 ch%0d both edges", ch), ci * 10 + ca, 12);
            end
        end
    endtask

    task automatic t_slow;
        int ci, ca, ed;
        write_cfg(8'h40);
        pulse_count(1, 62, 300, ci, ca, ed);
        check("R5 long filter 62-cycle glitch", ca, 0);
        pulse_count(1, 193, 300, ci, ca, ed);
        check("R5 R10 long filter 193-cycle pulse", ca, 1);
        write_cfg(8'hC0);
        pulse_count(1, 14, 100, ci, ca, ed);
        check("R5 short filter 14-cycle glitch", ca, 0);
        pulse_count(1, 49, 100, ci, ca, ed);
        check("R5 short filter 49-cycle pulse", ca, 1);
        pulse_count(1, 62, 100, ci, ca, ed);
        check("R5 short filter accepts 62-cycle pulse", ca, 1);
        pulse_count(1, 100, 100, ci, ca, ed);
        check("R7 ch1 bit1=0 rise seen in pulse", ci * 10 + ca, 11);
        write_cfg(8'hC2);
        pulse_count(1, 100, 100, ci, ca, ed);
        check("R7 ch1 bit1=1 fall seen after pulse", ci * 10 + ca, 1);
    endtask

    task automatic t_gate;
        int ci, ca, ed;
        write_cfg(8'h00);
        pulse_count(0, 30, 60, ci, ca, ed);
        check("R8 ch0 pin bit off blocks report", ca, 0);
        write_cfg(8'h40);
        master_en = 1'b0;
        pulse_count(4, 30, 60, ci, ca, ed);
        check("R9 master off blocks ch4", ca, 0);
        master_en = 1'b1;
        src_en[4] = 1'b0;
        pulse_count(4, 30, 60, ci, ca, ed);
        check("R9 source off blocks ch4", ca, 0);
        src_en[4] = 1'b1;
        pulse_count(4, 30, 60, ci, ca, ed);
        check("R9 ch4 reported once enables return", ca, 1);
    endtask

    task automatic t_blank;
        int ci, ca, ed;
        write_cfg(8'h40);
        @(negedge clk);
        pin_in[2] = 1'b1;
        cfg_we    = 1'b1;
        cfg_wdata = 8'h48;
        @(negedge clk);
        cfg_we = 1'b0;
        pulse_count(2, 150, 150, ci, ca, ed);
        check("R11 rise blanked after mode write", ci, 0);
        check("R11 later fall still reported", ca, 1);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_fast();
        t_mid();
        t_slow();
        t_gate();
        t_blank();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule